// File: doc/BRIEF.md
# Two-Stage Windowed Service Watchdog

This block is a watchdog timer that software must keep alive. While it is enabled, a down-counter runs on one of two tick inputs. Software restarts it by writing a two-word key to a service register, and that key reloads the counter from a 32-bit timeout register. If the counter runs out, the block escalates in two stages. The first expiry raises either an interrupt or a reset request, as configured. A second expiry with no valid service in between always raises a reset request.

In window mode, a service is only accepted once the counter has fallen to the window value or below. A service that arrives too early counts as an expiry.

All register writes are filtered by a per-master enable mask, indexed by a master-ID input. Configuration can be frozen in two ways. A soft lock can be lifted with a separate two-word unlock key. A hard lock is lifted only by reset. A reset-time input can start the watchdog enabled as soon as reset is released.

Top module: `service_watchdog`

Register offsets: 0 control, 1 timeout, 2 window, 3 service, 4 status, 5 counter (read only).

## Requirements
- R1: While control bit 0 is 1, the counter drops by one on each selected tick. A tick that arrives while the counter is 0 is an expiry. Writing 16'hA602 and then 16'hB480 to the service register reloads the counter from the timeout register. The counter can be read at offset 5.
- R2: Any other value written to the service register restarts key detection, and the following 16'hB480 does not reload the counter.
- R3: Control bit 1 picks the tick source: 0 selects the system tick input and 1 selects the oscillator tick input. The unselected tick has no effect on the counter.
- R4: With control bit 2 set, a service is accepted only when the counter is less than or equal to the window register. An earlier service is handled as an expiry.
- R5: On a first expiry, control bit 3 = 1 sets the interrupt flag (status bit 0, mirrored on the interrupt output), and bit 3 = 0 raises the reset request. The flag holds until software writes 1 to status bit 0. A valid service clears both the flag and the pending first-expiry state.
- R6: A second expiry with no valid service since the first always raises the reset request. The reset request then holds until reset.
- R7: Control bits 15:8 form a write-enable mask indexed by the master-ID input. A write from a master whose mask bit is 0 is ignored.
- R8: With soft lock set (control bit 4), writes to control, timeout and window are ignored. Writing 16'hC520 and then 16'hD928 to the service register clears the soft lock.
- R9: With hard lock set (control bit 5), writes to control, timeout and window are ignored. Only reset clears the hard lock; the unlock key does not.
- R10: After reset, control reads 32'h0000_FF08 with bit 0 taken from the reset-time enable input, and the counter holds the default timeout. While the watchdog is disabled, the counter follows the timeout register.
- R11: When a valid service completes on the same edge as an expiry tick, the service wins: the counter reloads and no interrupt or reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable_i | input | 1 | Reset-time enable value |
| tick_sys_i | input | 1 | System clock count enable |
| tick_osc_i | input | 1 | Oscillator clock count enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_mid_i | input | 3 | Master ID of the current access |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | First-expiry interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
Two events can fall on the same clock edge: the expiry tick, taken while the counter is 0, and the final word of the service key. The bench polls the counter until it reads 1, then writes the first key word so that the counter reaches 0. It then writes the second word on the very next edge, which also carries a tick. The result is judged correct only if the counter reads the full timeout afterwards and neither the interrupt nor the reset request has risen.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int MID_W  = 3;
    localparam int MASK_W = 1 << MID_W;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_TMO  = 3'd1,
        A_WIN  = 3'd2,
        A_SVC  = 3'd3,
        A_STAT = 3'd4,
        A_CNT  = 3'd5
    } reg_addr_e;

    localparam logic [15:0] SVC_KEY_A = 16'hA602;
    localparam logic [15:0] SVC_KEY_B = 16'hB480;
    localparam logic [15:0] UNL_KEY_A = 16'hC520;
    localparam logic [15:0] UNL_KEY_B = 16'hD928;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              hard_lock;
        logic              soft_lock;
        logic              first_irq;
        logic              win_en;
        logic              clk_sel;
        logic              en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SVC  = 2'd1,
        SEQ_UNL  = 2'd2
    } seq_e;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.clk_sel;
        w[2] = c.win_en;
        w[3] = c.first_irq;
        w[4] = c.soft_lock;
        w[5] = c.hard_lock;
        w[8 +: MASK_W] = c.mask;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en        = w[0];
        c.clk_sel   = w[1];
        c.win_en    = w[2];
        c.first_irq = w[3];
        c.soft_lock = w[4];
        c.hard_lock = w[5];
        c.mask      = w[8 +: MASK_W];
        return c;
    endfunction

endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        svc_o,
    output logic        unlock_o
);

    seq_e state_q, state_d;

    always_comb begin
        svc_o    = 1'b0;
        unlock_o = 1'b0;
        state_d  = state_q;
        if (wr_i) begin
            if (state_q == SEQ_SVC && data_i == SVC_KEY_B) begin
                svc_o   = 1'b1;
                state_d = SEQ_IDLE;
            end else if (state_q == SEQ_UNL && data_i == UNL_KEY_B) begin
                unlock_o = 1'b1;
                state_d  = SEQ_IDLE;
            end else if (data_i == SVC_KEY_A) begin
                state_d = SEQ_SVC;
            end else if (data_i == UNL_KEY_A) begin
                state_d = SEQ_UNL;
            end else begin
                state_d = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // R2
    wrong_word_no_service_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && data_i != SVC_KEY_A) |=> !svc_o);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int              CNT_W       = 32,
    parameter logic [CNT_W-1:0] DEF_TIMEOUT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic [CNT_W-1:0] window_i,
    input  logic             win_en_i,
    input  logic             first_irq_i,
    input  logic             svc_i,
    input  logic             irq_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q, irq_q, rreq_q;
    logic             early, good, expire, irq_set;

    always_comb begin
        early   = svc_i && en_i && win_en_i && (cnt_q > window_i);
        good    = svc_i && en_i && !early;
        expire  = en_i && !good && (early || (tick_i && cnt_q == '0));
        irq_set = expire && !pend_q && first_irq_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= DEF_TIMEOUT;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            if (irq_clr_i) irq_q <= 1'b0;
            if (!en_i) begin
                cnt_q  <= timeout_i;
                pend_q <= 1'b0;
            end else if (good) begin
                cnt_q  <= timeout_i;
                pend_q <= 1'b0;
                irq_q  <= 1'b0;
            end else if (expire) begin
                cnt_q <= timeout_i;
                if (pend_q) begin
                    rreq_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                    if (first_irq_i) irq_q  <= 1'b1;
                    else             rreq_q <= 1'b1;
                end
            end else if (tick_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rreq_q;

    // R6
    rst_req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o);

    // R4
    early_service_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_i && en_i && win_en_i && cnt_q > window_i) |=> (irq_o || rst_req_o));

    // R11
    service_reloads_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_i && en_i && !win_en_i) |=> (cnt_o == $past(timeout_i)));

    // R5
    irq_set_visible_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq_o);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter logic [CNT_W-1:0] DEF_TIMEOUT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [MID_W-1:0]  mid_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    input  logic              rst_req_i,
    input  logic              unlock_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  timeout_o,
    output logic [CNT_W-1:0]  window_o,
    output logic              svc_wr_o,
    output logic              irq_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic wr_ok, cfg_open;

    assign wr_ok     = wr_i && ctrl_o.mask[mid_i];
    assign cfg_open  = !ctrl_o.soft_lock && !ctrl_o.hard_lock;
    assign svc_wr_o  = wr_ok && (addr_i == A_SVC);
    assign irq_clr_o = wr_ok && (addr_i == A_STAT) && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o.en        <= cfg_en_i;
            ctrl_o.clk_sel   <= 1'b0;
            ctrl_o.win_en    <= 1'b0;
            ctrl_o.first_irq <= 1'b1;
            ctrl_o.soft_lock <= 1'b0;
            ctrl_o.hard_lock <= 1'b0;
            ctrl_o.mask      <= '1;
            timeout_o        <= DEF_TIMEOUT;
            window_o         <= '0;
        end else begin
            if (unlock_i) ctrl_o.soft_lock <= 1'b0;
            if (wr_ok && cfg_open) begin
                case (addr_i)
                    A_CTRL:  ctrl_o    <= unpack_ctrl(wdata_i);
                    A_TMO:   timeout_o <= wdata_i[CNT_W-1:0];
                    A_WIN:   window_o  <= wdata_i[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = pack_ctrl(ctrl_o);
            A_TMO:   rdata_o = DATA_W'(timeout_o);
            A_WIN:   rdata_o = DATA_W'(window_o);
            A_STAT:  rdata_o = DATA_W'({rst_req_i, irq_i});
            A_CNT:   rdata_o = DATA_W'(cnt_i);
            default: rdata_o = '0;
        endcase
    end

    // R7
    foreign_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !ctrl_o.mask[mid_i]) |=> ($stable(timeout_o) && $stable(window_o)));

    // R8
    locked_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (ctrl_o.soft_lock || ctrl_o.hard_lock)) |=> $stable(timeout_o));

    // R9
    hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.hard_lock |=> ctrl_o.hard_lock);

endmodule

// File: rtl/service_watchdog.sv
module service_watchdog
    import wdg_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter logic [CNT_W-1:0] DEF_TIMEOUT = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable_i,
    input  logic              tick_sys_i,
    input  logic              tick_osc_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [MID_W-1:0]  bus_mid_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] timeout, window, cnt;
    logic             svc_wr, irq_clr, svc_done, unlock, tick;

    assign tick = ctrl.clk_sel ? tick_osc_i : tick_sys_i;

    wdg_regs #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_en_i  (cfg_enable_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .mid_i     (bus_mid_i),
        .cnt_i     (cnt),
        .irq_i     (irq_o),
        .rst_req_i (rst_req_o),
        .unlock_i  (unlock),
        .ctrl_o    (ctrl),
        .timeout_o (timeout),
        .window_o  (window),
        .svc_wr_o  (svc_wr),
        .irq_clr_o (irq_clr),
        .rdata_o   (bus_rdata_o)
    );

    wdg_key_seq keys_i (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (svc_wr),
        .data_i   (bus_wdata_i[15:0]),
        .svc_o    (svc_done),
        .unlock_o (unlock)
    );

    wdg_counter #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.en),
        .tick_i      (tick),
        .timeout_i   (timeout),
        .window_i    (window),
        .win_en_i    (ctrl.win_en),
        .first_irq_i (ctrl.first_irq),
        .svc_i       (svc_done),
        .irq_clr_i   (irq_clr),
        .cnt_o       (cnt),
        .irq_o       (irq_o),
        .rst_req_o   (rst_req_o)
    );

endmodule

// File: tb/service_watchdog_tb.sv
`timescale 1ns/1ps
module service_watchdog_tb_top;

    localparam logic [31:0] DEF_T = 32'd200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable_i = 1'b0;
    logic        tick_sys_i = 1'b1;
    logic        tick_osc_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = 3'd0;
    logic [31:0] bus_wdata_i = '0;
    logic [2:0]  bus_mid_i = 3'd0;
    logic [31:0] bus_rdata_o;
    logic        irq_o, rst_req_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    service_watchdog #(.CNT_W(32), .DEF_TIMEOUT(DEF_T)) dut_i (
        .clk(clk), .rst(rst), .cfg_enable_i(cfg_enable_i),
        .tick_sys_i(tick_sys_i), .tick_osc_i(tick_osc_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_mid_i(bus_mid_i), .bus_rdata_o(bus_rdata_o),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [31:0] mk(input logic en, input logic cs, input logic win,
                                       input logic fi, input logic sl, input logic hl);
        return {16'h0, 8'hFF, 2'b00, hl, sl, fi, win, cs, en};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en);
        @(negedge clk);
        cfg_enable_i = en;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick_sys_i = 1'b1;
        tick_osc_i = 1'b0;
        bus_mid_i = 3'd0;
    endtask

    // called just after a negedge; returns just after the next negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr_i = a;
        bus_wdata_i = d;
        bus_wr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic service();
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'hB480);
    endtask

    task automatic wait_sig(input bit want_rst, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (want_rst ? rst_req_o : irq_o) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(1'b0);
        rd(3'd0, d); check("R10 ctrl reset", d, 32'h0000_FF08);
        rd(3'd5, d); check("R10 counter default", d, DEF_T);
        check("R10 irq reset", 32'(irq_o), 0);
        check("R10 rst_req reset", 32'(rst_req_o), 0);
        do_reset(1'b1);
        rd(3'd0, d); check("R10 enabled from reset", d, 32'h0000_FF09);
        repeat (4) @(negedge clk);
        rd(3'd5, d); check("R10 counts after reset", d, DEF_T - 4);
    endtask

    task automatic t_service_keys();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd50);
        wr(3'd0, mk(1, 0, 0, 1, 0, 0));
        service();
        rd(3'd5, d); check("R1 service reload", d, 32'd50);
        wr(3'd3, 32'hA602);
        wr(3'd3, 32'h1234);
        wr(3'd3, 32'hB480);
        rd(3'd5, d); check("R2 wrong word blocks reload", d, 32'd47);
    endtask

    task automatic t_clk_sel();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd50);
        wr(3'd0, mk(1, 1, 0, 1, 0, 0));
        repeat (5) @(negedge clk);
        rd(3'd5, d); check("R3 system tick ignored", d, 32'd50);
        tick_osc_i = 1'b1;
        repeat (3) @(negedge clk);
        tick_osc_i = 1'b0;
        rd(3'd5, d); check("R3 oscillator tick counts", d, 32'd47);
    endtask

    task automatic t_two_stage();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd10);
        wr(3'd0, mk(1, 0, 0, 1, 0, 0));
        wait_sig(1'b0, 100);
        check("R5 first expiry irq", 32'(irq_o), 1);
        check("R5 no reset on first", 32'(rst_req_o), 0);
        rd(3'd4, d); check("R5 status flag", d, 32'h1);
        wr(3'd4, 32'h1);
        check("R5 w1c clears irq", 32'(irq_o), 0);
        wait_sig(1'b1, 100);
        check("R6 second expiry reset", 32'(rst_req_o), 1);
        repeat (30) @(negedge clk);
        check("R6 reset request holds", 32'(rst_req_o), 1);
    endtask

    task automatic t_service_clears();
        do_reset(1'b0);
        wr(3'd1, 32'd10);
        wr(3'd0, mk(1, 0, 0, 1, 0, 0));
        wait_sig(1'b0, 100);
        service();
        check("R5 service clears irq", 32'(irq_o), 0);
        wait_sig(1'b0, 100);
        check("R5 pending cleared: irq again", 32'(irq_o), 1);
        check("R5 pending cleared: no reset", 32'(rst_req_o), 0);
    endtask

    task automatic t_reset_mode();
        do_reset(1'b0);
        wr(3'd1, 32'd5);
        wr(3'd0, mk(1, 0, 0, 0, 0, 0));
        wait_sig(1'b1, 60);
        check("R5 reset-mode first expiry", 32'(rst_req_o), 1);
        check("R5 reset-mode no irq", 32'(irq_o), 0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd40);
        wr(3'd2, 32'd5);
        wr(3'd0, mk(1, 0, 1, 1, 0, 0));
        service();
        check("R4 early service is expiry", 32'(irq_o), 1);
        do_reset(1'b0);
        wr(3'd1, 32'd40);
        wr(3'd2, 32'd5);
        wr(3'd0, mk(1, 0, 1, 1, 0, 0));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(3'd5, d);
            if (d <= 32'd5) break;
        end
        service();
        rd(3'd5, d); check("R4 in-window service reload", d, 32'd40);
        check("R4 in-window no irq", 32'(irq_o), 0);
    endtask

    task automatic t_same_edge();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd30);
        wr(3'd0, mk(1, 0, 0, 1, 0, 0));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(3'd5, d);
            if (d == 32'd1) break;
        end
        service();
        rd(3'd5, d); check("R11 service wins reload", d, 32'd30);
        check("R11 no irq", 32'(irq_o), 0);
        check("R11 no reset", 32'(rst_req_o), 0);
    endtask

    task automatic t_master();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd60);
        wr(3'd0, {16'h0, 8'h01, 8'h08});
        bus_mid_i = 3'd3;
        wr(3'd1, 32'd77);
        rd(3'd1, d); check("R7 masked master ignored", d, 32'd60);
        bus_mid_i = 3'd0;
        wr(3'd1, 32'd77);
        rd(3'd1, d); check("R7 enabled master writes", d, 32'd77);
    endtask

    task automatic t_locks();
        logic [31:0] d;
        do_reset(1'b0);
        wr(3'd1, 32'd60);
        wr(3'd0, mk(0, 0, 0, 1, 1, 0));
        wr(3'd1, 32'd99);
        rd(3'd1, d); check("R8 soft lock blocks", d, 32'd60);
        wr(3'd3, 32'hC520);
        wr(3'd3, 32'hD928);
        rd(3'd0, d); check("R8 unlock clears soft", d & 32'h10, 32'h0);
        wr(3'd1, 32'd99);
        rd(3'd1, d); check("R8 write after unlock", d, 32'd99);
        wr(3'd0, mk(0, 0, 0, 1, 0, 1));
        wr(3'd3, 32'hC520);
        wr(3'd3, 32'hD928);
        wr(3'd1, 32'd11);
        rd(3'd1, d); check("R9 hard lock blocks", d, 32'd99);
        rd(3'd0, d); check("R9 unlock key no effect", d & 32'h20, 32'h20);
        do_reset(1'b0);
        rd(3'd0, d); check("R9 reset clears hard", d & 32'h20, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_service_keys();
        t_clk_sel();
        t_two_stage();
        t_service_clears();
        t_reset_mode();
        t_window();
        t_same_edge();
        t_master();
        t_locks();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule